// File: doc/BRIEF.md
# Parallel Flash Bus Front-End

This block is the device-side pin interface of a parallel NOR-style flash memory, modelled inside a synchronous clock domain. The asynchronous bus pins (three active-low enables, output enable, write strobe, reset/power-down, width select, address and data) pass through synchronisers. From the synchronised samples the block works out whether the device is selected. It detects the end of each bus write cycle and hands the captured address and word to an internal command interface as a single-cycle pulse.

On the read side, an internal source-select code picks one of five word-wide data sources: the array, the identifier, the protection status, the query table or the status word. The block places the chosen data on the data bus, with per-lane output enables, and substitutes a busy indication on bit 7 while the program/erase engine runs. A width pin chooses between a 16-bit word bus and an 8-bit byte bus. In byte mode the lowest address bit picks the byte lane.

Top module: `pflash_bus_fe`

## Requirements
- R1: The device counts as selected only while all three `ce_n_i` are low and `rp_n_i` is high. Deasserting any one enable deselects it.
- R2: A write cycle that ends with a rising `we_n_i` while the device is selected produces exactly one cycle of `cmd_valid_o`, carrying the address and data that were on the pins before the strobe rose.
- R3: A write cycle that ends because an enable rises while `we_n_i` is still low is captured at that deselect edge. The later rise of `we_n_i` produces no second capture.
- R4: Each write cycle yields exactly one `cmd_valid_o` pulse, also when the strobe and an enable rise in the same sample.
- R5: `dq_oe_o` is nonzero only while the device is selected, `oe_n_i` is low and `rp_n_i` is high. When not driving, `dq_o` is zero. Pin changes reach `dq_o`/`dq_oe_o` after three rising clock edges, and internal inputs reach them after one.
- R6: `rd_sel_i` codes are 0 array, 1 identifier, 2 protection, 3 query table, 4 status. Codes 5 to 7 read the array.
- R7: While `pec_busy_i` is high, bit 7 of the driven lane (`dq_o[7]`) reads 0 whatever the source holds.
- R8: With `wide_i` low (byte mode), `dq_oe_o` is 16'h00FF. `dq_o[7:0]` carries source bits [7:0] when A0 is 0 and bits [15:8] when A0 is 1.
- R9: With `wide_i` high (word mode), `dq_oe_o` is 16'hFFFF and the full word is driven. A0 has no effect on read data, and `cmd_addr_o[0]` is 0. `rd_addr_o` always equals address bits [22:1].
- R10: A byte-mode write reports A0 in `cmd_addr_o[0]`, and reports `cmd_data_o` as {8'h00, data[7:0]}.
- R11: While `rp_n_i` is low, the bus is not driven and no write is captured, whatever the other pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_n_i | input | 3 | Active-low chip enables (pins) |
| oe_n_i | input | 1 | Active-low output enable (pin) |
| we_n_i | input | 1 | Active-low write strobe (pin) |
| rp_n_i | input | 1 | Active-low reset/power-down (pin) |
| wide_i | input | 1 | Bus width: 1 word, 0 byte (pin) |
| addr_i | input | 23 | Address pins, bit 0 is the byte select |
| dq_i | input | 16 | Data bus input side |
| dq_o | output | 16 | Data bus output side |
| dq_oe_o | output | 16 | Per-bit output enable for the data bus |
| rd_sel_i | input | 3 | Read source code |
| arr_data_i | input | 16 | Array word |
| sig_data_i | input | 16 | Identifier word |
| prot_data_i | input | 16 | Block protection word |
| cfi_data_i | input | 16 | Query table word |
| stat_data_i | input | 16 | Status word |
| pec_busy_i | input | 1 | Program/erase engine busy |
| rd_addr_o | output | 22 | Word address toward the data sources |
| cmd_valid_o | output | 1 | One-cycle write capture pulse |
| cmd_addr_o | output | 23 | Captured address |
| cmd_data_o | output | 16 | Captured command or data word |

## Verification
The bench ends write cycles in three ways: by the strobe, by each enable in turn, and by strobe and enable together. A design that ignores the deselect edge would miss the second kind. A design that does not disarm after capture would emit a second pulse when the strobe rises later. The scoreboard would report either one as a missing item or an unexpected item. Reads walk every source code, including the unused ones, in both widths and with both A0 values. The bench also sets the busy flag against a source word whose bit 7 is 1, so a swapped byte lane, a wrong upper-lane enable or a missing bit-7 override shows up as a data mismatch. Writes and reads attempted while reset/power-down is low must leave the bus undriven and the scoreboard empty.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  typedef enum logic [2:0] {
    SRC_ARRAY  = 3'd0,
    SRC_SIG    = 3'd1,
    SRC_PROT   = 3'd2,
    SRC_CFI    = 3'd3,
    SRC_STATUS = 3'd4
  } rd_src_e;
endpackage

// File: rtl/pfb_sync.sv
module pfb_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pfb_capture.sv
module pfb_capture #(
  parameter int ADDR_W = 23,
  parameter int DQ_W   = 16,
  parameter int NUM_CE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CE-1:0] ce_n_i,
  input  logic              we_n_i,
  input  logic              rp_n_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic              sel_o,
  output logic              cmd_valid_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DQ_W-1:0]   cmd_data_o
);
  localparam int BYTE_W = DQ_W / 2;

  logic              sel, sel_q, we_q, wide_q, armed, we_rise, desel, end_evt;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   dq_q;

  assign sel     = rp_n_i & ~(|ce_n_i);
  assign sel_o   = sel;
  assign we_rise = we_n_i & ~we_q;
  assign desel   = sel_q & ~sel;
  // first of strobe rise or deselect closes the write cycle
  assign end_evt = armed & rp_n_i & (we_rise | desel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      we_q   <= 1'b1;
      wide_q <= 1'b1;
      addr_q <= '0;
      dq_q   <= '0;
      armed  <= 1'b0;
    end else begin
      sel_q  <= sel;
      we_q   <= we_n_i;
      wide_q <= wide_i;
      addr_q <= addr_i;
      dq_q   <= dq_i;
      if (!rp_n_i || end_evt) armed <= 1'b0;
      else if (sel && !we_n_i) armed <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      cmd_addr_o  <= '0;
      cmd_data_o  <= '0;
    end else begin
      cmd_valid_o <= end_evt;
      if (end_evt) begin
        cmd_addr_o <= wide_q ? {addr_q[ADDR_W-1:1], 1'b0} : addr_q;
        cmd_data_o <= wide_q ? dq_q : {{(DQ_W-BYTE_W){1'b0}}, dq_q[BYTE_W-1:0]};
      end
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  a_r11_no_capture_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rp_n_i |=> !cmd_valid_o);
  a_r3_no_capture_unselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_q && !sel) |=> !cmd_valid_o);
endmodule

// File: rtl/pfb_read_out.sv
module pfb_read_out
  import pfb_pkg::*;
#(
  parameter int DQ_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,
  input  logic            oe_n_i,
  input  logic            rp_n_i,
  input  logic            wide_i,
  input  logic            a0_i,
  input  logic [2:0]      rd_sel_i,
  input  logic [DQ_W-1:0] arr_data_i,
  input  logic [DQ_W-1:0] sig_data_i,
  input  logic [DQ_W-1:0] prot_data_i,
  input  logic [DQ_W-1:0] cfi_data_i,
  input  logic [DQ_W-1:0] stat_data_i,
  input  logic            busy_i,
  output logic [DQ_W-1:0] dq_o,
  output logic [DQ_W-1:0] dq_oe_o
);
  localparam int BYTE_W   = DQ_W / 2;
  localparam int NUM_LANE = 2;

  logic [DQ_W-1:0]     word, dq_d, oe_d;
  logic [BYTE_W-1:0]   lane_lo, lane_hi;
  logic [NUM_LANE-1:0] lane_en;
  logic                drive;

  always_comb begin
    unique case (rd_src_e'(rd_sel_i))
      SRC_SIG:    word = sig_data_i;
      SRC_PROT:   word = prot_data_i;
      SRC_CFI:    word = cfi_data_i;
      SRC_STATUS: word = stat_data_i;
      default:    word = arr_data_i;
    endcase
  end

  always_comb begin
    lane_lo = (!wide_i && a0_i) ? word[DQ_W-1:BYTE_W] : word[BYTE_W-1:0];
    if (busy_i) lane_lo[7] = 1'b0;
    lane_hi = wide_i ? word[DQ_W-1:BYTE_W] : '0;
  end

  assign drive = sel_i & ~oe_n_i & rp_n_i;

  for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane
    assign lane_en[g] = drive & ((g == 0) | wide_i);
    assign oe_d[g*BYTE_W +: BYTE_W] = {BYTE_W{lane_en[g]}};
  end

  assign dq_d = drive ? {lane_hi, lane_lo} : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_o    <= '0;
      dq_oe_o <= '0;
    end else begin
      dq_o    <= dq_d;
      dq_oe_o <= oe_d;
    end
  end

  a_r5_hiz_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && !oe_n_i) |=> (dq_oe_o == '0 && dq_o == '0));
  a_r8_upper_hiz_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i |=> (dq_oe_o[DQ_W-1:BYTE_W] == '0));
  a_r7_busy_bit7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !dq_o[7]);
  a_r11_reset_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rp_n_i |=> (dq_oe_o == '0));
endmodule

// File: rtl/pflash_bus_fe.sv
module pflash_bus_fe #(
  parameter int ADDR_W      = 23,
  parameter int DQ_W        = 16,
  parameter int NUM_CE      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CE-1:0] ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic              rp_n_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic [DQ_W-1:0]   dq_o,
  output logic [DQ_W-1:0]   dq_oe_o,
  input  logic [2:0]        rd_sel_i,
  input  logic [DQ_W-1:0]   arr_data_i,
  input  logic [DQ_W-1:0]   sig_data_i,
  input  logic [DQ_W-1:0]   prot_data_i,
  input  logic [DQ_W-1:0]   cfi_data_i,
  input  logic [DQ_W-1:0]   stat_data_i,
  input  logic              pec_busy_i,
  output logic [ADDR_W-2:0] rd_addr_o,
  output logic              cmd_valid_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DQ_W-1:0]   cmd_data_o
);
  localparam int PIN_W = NUM_CE + 4 + ADDR_W + DQ_W;
  localparam logic [PIN_W-1:0] PIN_RST =
    {{NUM_CE{1'b1}}, 1'b1, 1'b1, 1'b0, 1'b1, {ADDR_W{1'b0}}, {DQ_W{1'b0}}};

  logic [PIN_W-1:0]  pin_raw, pin_s;
  logic [NUM_CE-1:0] ce_s;
  logic              oe_s, we_s, rp_s, wide_s, sel;
  logic [ADDR_W-1:0] addr_s;
  logic [DQ_W-1:0]   dq_s;

  assign pin_raw = {ce_n_i, oe_n_i, we_n_i, rp_n_i, wide_i, addr_i, dq_i};

  pfb_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_raw), .q_o(pin_s)
  );

  assign {ce_s, oe_s, we_s, rp_s, wide_s, addr_s, dq_s} = pin_s;
  assign rd_addr_o = addr_s[ADDR_W-1:1];

  pfb_capture #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .NUM_CE(NUM_CE)) u_cap (
    .clk_i, .rst_ni,
    .ce_n_i(ce_s), .we_n_i(we_s), .rp_n_i(rp_s), .wide_i(wide_s),
    .addr_i(addr_s), .dq_i(dq_s),
    .sel_o(sel), .cmd_valid_o, .cmd_addr_o, .cmd_data_o
  );

  pfb_read_out #(.DQ_W(DQ_W)) u_rd (
    .clk_i, .rst_ni,
    .sel_i(sel), .oe_n_i(oe_s), .rp_n_i(rp_s), .wide_i(wide_s), .a0_i(addr_s[0]),
    .rd_sel_i, .arr_data_i, .sig_data_i, .prot_data_i, .cfi_data_i, .stat_data_i,
    .busy_i(pec_busy_i), .dq_o, .dq_oe_o
  );
endmodule

// File: tb/sim_pflash_bus_fe.sv
`timescale 1ns/1ps
module sim_pflash_bus_fe;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  ce_n = 3'b111;
  logic        oe_n = 1'b1, we_n = 1'b1, rp_n = 1'b1, wide = 1'b1;
  logic [22:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, dq_oe;
  logic [2:0]  rd_sel = 3'd0;
  logic [15:0] arr_d = 16'hA55A, sig_d = 16'h1289, prot_d = 16'h0001,
               cfi_d = 16'h5152, stat_d = 16'h80FF;
  logic        busy = 1'b0;
  logic [21:0] rd_addr;
  logic        cmd_valid;
  logic [22:0] cmd_addr;
  logic [15:0] cmd_data;

  int checks = 0, failures = 0;
  logic [38:0] expq [$];

  always #4 clk = ~clk;

  pflash_bus_fe u0 (
    .clk_i(clk), .rst_ni, .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n), .rp_n_i(rp_n),
    .wide_i(wide), .addr_i(addr), .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe),
    .rd_sel_i(rd_sel), .arr_data_i(arr_d), .sig_data_i(sig_d), .prot_data_i(prot_d),
    .cfi_data_i(cfi_d), .stat_data_i(stat_d), .pec_busy_i(busy), .rd_addr_o(rd_addr),
    .cmd_valid_o(cmd_valid), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && cmd_valid) begin
      if (expq.size() == 0) chk(1'b0, "R4 unexpected capture", {25'd0, cmd_addr, cmd_data}, 64'd0);
      else begin
        logic [38:0] e;
        e = expq.pop_front();
        chk({cmd_addr, cmd_data} == e, "R2 capture contents", {25'd0, cmd_addr, cmd_data}, {25'd0, e});
      end
    end
  end

  function automatic logic [31:0] exp_rd(input int code, input bit bz, input bit w, input bit a0, input bit drv);
    logic [15:0] word;
    logic [7:0]  lo, hi;
    case (code)
      1: word = sig_d;
      2: word = prot_d;
      3: word = cfi_d;
      4: word = stat_d;
      default: word = arr_d;
    endcase
    lo = (!w && a0) ? word[15:8] : word[7:0];
    if (bz) lo[7] = 1'b0;
    hi = w ? word[15:8] : 8'h00;
    if (!drv) return 32'h0;
    return {(w ? 16'hFFFF : 16'h00FF), hi, lo};
  endfunction

  task automatic rd_check(input string tag, input int code, input bit drv);
    logic [31:0] e;
    rd_sel = code[2:0];
    tick(4);
    e = exp_rd(code, busy, wide, addr[0], drv);
    chk({dq_oe, dq_out} == e, tag, {32'd0, dq_oe, dq_out}, {32'd0, e});
  endtask

  // how: 0 strobe end, 1 enable end, 2 both at once
  task automatic wr(input logic [22:0] a, input logic [15:0] d, input int how, input int ce_idx, input bit exp_it);
    addr = a; dq_in = d; oe_n = 1'b1;
    ce_n = 3'b000; tick(3);
    we_n = 1'b0; tick(3);
    if (exp_it) expq.push_back({(wide ? {a[22:1], 1'b0} : a), (wide ? d : {8'h00, d[7:0]})});
    case (how)
      0: we_n = 1'b1;
      1: ce_n[ce_idx] = 1'b1;
      default: begin we_n = 1'b1; ce_n[ce_idx] = 1'b1; end
    endcase
    tick(5);
    we_n = 1'b1; ce_n = 3'b111;
    tick(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    chk(dq_oe == 16'h0 && !cmd_valid, "R5 reset state", {47'd0, cmd_valid, dq_oe}, 64'd0);

    // reads, word mode
    addr = 23'h2AAAA5; ce_n = 3'b000; oe_n = 1'b0;
    for (int c = 0; c < 8; c++) rd_check($sformatf("R6 word read code %0d", c), c, 1'b1);
    chk(rd_addr == 22'h155552, "R9 rd_addr word address", {42'd0, rd_addr}, 64'h155552);
    addr = 23'h2AAAA4;
    rd_check("R9 A0 ignored in word mode", 0, 1'b1);
    oe_n = 1'b1;
    rd_check("R5 oe high no drive", 0, 1'b0);
    oe_n = 1'b0; ce_n = 3'b100;
    rd_check("R1 enable 2 high no drive", 0, 1'b0);
    ce_n = 3'b010;
    rd_check("R1 enable 1 high no drive", 0, 1'b0);
    ce_n = 3'b000; busy = 1'b1;
    rd_check("R7 busy word status", 4, 1'b1);
    rd_check("R7 busy word array", 0, 1'b1);
    busy = 1'b0;

    // reads, byte mode
    wide = 1'b0; addr = 23'h000010;
    rd_check("R8 byte low lane", 0, 1'b1);
    addr = 23'h000011;
    rd_check("R8 byte high lane", 0, 1'b1);
    rd_check("R8 byte high lane status", 4, 1'b1);
    busy = 1'b1;
    rd_check("R7 busy byte high lane", 4, 1'b1);
    busy = 1'b0;
    wide = 1'b1;

    // reset/power-down
    rp_n = 1'b0;
    rd_check("R11 reset no drive", 0, 1'b0);
    rp_n = 1'b1;
    rd_check("R11 drive after release", 0, 1'b1);
    oe_n = 1'b1; ce_n = 3'b111; tick(4);

    // writes
    wr(23'h123457, 16'hBEEF, 0, 0, 1'b1);   // R2
    for (int k = 0; k < 3; k++) wr(23'h0F0F00 + 23'(k), 16'h1000 + 16'(k), 1, k, 1'b1); // R3
    wr(23'h7FFFFF, 16'h00C3, 2, 2, 1'b1);   // R4
    wide = 1'b0;
    wr(23'h000033, 16'hABCD, 0, 0, 1'b1);   // R10
    wr(23'h000032, 16'h5A7E, 1, 1, 1'b1);   // R10
    wide = 1'b1;
    rp_n = 1'b0;
    wr(23'h001000, 16'hDEAD, 0, 0, 1'b0);   // R11
    rp_n = 1'b1; tick(4);
    chk(expq.size() == 0, "R2 all captures seen", 64'(expq.size()), 64'd0);
    chk(!cmd_valid, "R4 idle after writes", {63'd0, cmd_valid}, 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule